// File: doc/BRIEF.md
# Byte-Wide DMA Channel Register File

This block is the register file that a host processor sees in a four-channel DMA controller. The host reaches it through an 8-bit bus with a 4-bit register offset, a read strobe and a write strobe. Each channel holds a 16-bit transfer address and a 16-bit transfer count. Because the data port is only one byte wide, both values are loaded and read in two accesses.

One byte-select flip-flop is shared by every channel. It picks the low byte while it is clear and the high byte while it is set. It flips after every access to any address or count register, and only a write to a dedicated offset returns it to the low state. The block also holds a request mask bit and a 6-bit mode field for each channel. The mask can be changed one channel at a time, cleared for all channels, or loaded as a whole. The mask vector and the mode fields go to the transfer engine. Address and count readback return the working values one byte per access.

A driver first writes the clear-pointer offset. It then writes the low and high bytes of a channel's address and count, programs the channel's mode and unmasks the channel. The count value written is one less than the number of transfers wanted.

Top module: `dma_regfile`

## Requirements
- R1: After reset, mask_o is 4'hF, all mode fields are zero, the byte pointer selects the low byte, and every address and count reads back as zero.
- R2: Channel n keeps its address at offset 2n and its count at offset 2n+1, for n from 0 to 3. A write with the pointer clear loads bits 7:0 and a write with the pointer set loads bits 15:8.
- R3: The byte pointer is one flip-flop shared by all channels. It toggles after each read or write of offsets 0 to 7, whichever channel is addressed. Accesses to other offsets leave it unchanged.
- R4: A write to offset 0xC clears the byte pointer, whatever the data byte holds.
- R5: A write to offset 0xA changes the mask bit of the channel given by data bits 1:0. Data bit 2 set masks that channel and bit 2 clear unmasks it. The other channels and data bits 7:3 have no effect.
- R6: A write to offset 0xE clears all four mask bits, whatever the data byte holds.
- R7: A write to offset 0xF loads mask_o from data bits 3:0, with bit n belonging to channel n.
- R8: A write to offset 0xB stores data bits 7:2 as the mode of the channel given by data bits 1:0. The mode appears on mode_o bits 6n+5:6n, and the other channels' modes are unchanged.
- R9: While rd_en is high at offsets 0 to 7, rdata shows the addressed register's low byte (pointer clear) or high byte (pointer set) in the same cycle. At all other times rdata is zero.
- R10: The count register stores the written value as is. A count of N transfers is written as N-1, so 0x00FF reads back as 0x00FF.
- R11: When rd_en and wr_en are both high at one channel offset, rdata shows the value before the write, the write takes effect, and the pointer toggles only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 4 | Register offset |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe, one access per cycle |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte, valid in the cycle of rd_en |
| mask_o | output | 4 | Per-channel request mask to the transfer engine |
| mode_o | output | 24 | Per-channel 6-bit mode fields, channel n at bits 6n+5:6n |

## Verification
A wrong byte pointer shows at the port on the very next channel access: the byte lands in the wrong half or comes back from the wrong half. The bench therefore interleaves accesses across channels and checks readback after each sequence. A corrupted mask or mode bit appears on mask_o or mode_o one cycle after the command write, and the bench samples those outputs immediately after every command. A stray pointer toggle from a non-channel offset shows up as swapped bytes in the next two-byte readback.

// File: rtl/dma_regfile.sv
module dma_regfile #(
  parameter int NCH = 4,
  parameter int AW  = 4,
  parameter int DW  = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [AW-1:0]               addr,
  input  logic                        wr_en,
  input  logic                        rd_en,
  input  logic [DW-1:0]               wdata,
  output logic [DW-1:0]               rdata,
  output logic [NCH-1:0]              mask_o,
  output logic [NCH*(DW-$clog2(NCH))-1:0] mode_o
);
  localparam int CHW = $clog2(NCH);
  localparam int MW  = DW - CHW;
  localparam int RW  = 2 * DW;
  localparam logic [AW-1:0] OFF_SMASK  = AW'(4'hA);
  localparam logic [AW-1:0] OFF_MODE   = AW'(4'hB);
  localparam logic [AW-1:0] OFF_CLRPTR = AW'(4'hC);
  localparam logic [AW-1:0] OFF_CLRMSK = AW'(4'hE);
  localparam logic [AW-1:0] OFF_MSKALL = AW'(4'hF);

  logic [RW-1:0]  addr_q [NCH];
  logic [RW-1:0]  cnt_q  [NCH];
  logic [MW-1:0]  mode_q [NCH];
  logic [NCH-1:0] mask_q;
  logic           ptr_q;

  wire            ch_acc = addr < AW'(2 * NCH);
  wire [CHW-1:0]  ch     = addr[CHW:1];
  wire            is_cnt = addr[0];
  wire [CHW-1:0]  cmd_ch = wdata[CHW-1:0];
  wire            acc    = (rd_en || wr_en) && ch_acc;
  wire            clr    = wr_en && addr == OFF_CLRPTR;
  wire [RW-1:0]   sel    = is_cnt ? cnt_q[ch] : addr_q[ch];

  assign rdata  = (rd_en && ch_acc) ? (ptr_q ? sel[RW-1:DW] : sel[DW-1:0]) : '0;
  assign mask_o = mask_q;

  for (genvar g = 0; g < NCH; g++) begin : g_mode
    assign mode_o[g*MW +: MW] = mode_q[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        addr_q[i] <= '0;
        cnt_q[i]  <= '0;
        mode_q[i] <= '0;
      end
      mask_q <= '1;
      ptr_q  <= 1'b0;
    end else begin
      if (clr)      ptr_q <= 1'b0;
      else if (acc) ptr_q <= ~ptr_q;
      if (wr_en) begin
        if (ch_acc) begin
          if (is_cnt) begin
            if (ptr_q) cnt_q[ch][RW-1:DW] <= wdata;
            else       cnt_q[ch][DW-1:0]  <= wdata;
          end else begin
            if (ptr_q) addr_q[ch][RW-1:DW] <= wdata;
            else       addr_q[ch][DW-1:0]  <= wdata;
          end
        end
        case (addr)
          OFF_SMASK:  mask_q[cmd_ch] <= wdata[CHW];
          OFF_MODE:   mode_q[cmd_ch] <= wdata[DW-1:CHW];
          OFF_CLRMSK: mask_q <= '0;
          OFF_MSKALL: mask_q <= wdata[NCH-1:0];
          default: ;
        endcase
      end
    end
  end

  // R3
  ptr_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> ptr_q != $past(ptr_q));
  // R3
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc && !clr) |=> $stable(ptr_q));
  // R4
  ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !ptr_q);
  // R6
  mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFF_CLRMSK) |=> mask_o == '0);
  // R7
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFF_MSKALL) |=> mask_o == $past(wdata[NCH-1:0]));
  // R9
  rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rdata == '0);
endmodule

// File: tb/dma_regfile_bench.sv
module dma_regfile_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [3:0] mask_o;
  logic [23:0] mode_o;

  int n_chk = 0, n_bad = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #2.5 clk = ~clk;

  dma_regfile u_dma_regfile (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .mask_o(mask_o), .mode_o(mode_o));

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rd_en) begin
      if (exp_q.size() == 0) chk(32'hDEAD, 32'h0, "monitor: unexpected read");
      else chk({24'h0, rdata}, {24'h0, exp_q.pop_front()}, tag_q.pop_front());
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    addr = a; rd_en = 1'b1;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic rdwr(input logic [3:0] a, input logic [7:0] d, input logic [7:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    addr = a; wdata = d; rd_en = 1'b1; wr_en = 1'b1;
    @(posedge clk); #1;
    rd_en = 1'b0; wr_en = 1'b0;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk(mask_o, 4'hF, "R1 mask after reset");
    chk(mode_o, 24'h0, "R1 mode after reset");
    chk(rdata, 0, "R9 idle rdata");
    rd(4'h0, 8'h00, "R1 ch0 addr low");
    rd(4'h0, 8'h00, "R1 ch0 addr high");
    rd(4'h7, 8'h00, "R1 ch3 count low");
    rd(4'h7, 8'h00, "R1 ch3 count high");

    wr(4'h2, 8'h34); wr(4'h2, 8'h12);
    wr(4'h3, 8'hFF); wr(4'h3, 8'h00);
    rd(4'h2, 8'h34, "R2 ch1 addr low");
    rd(4'h2, 8'h12, "R2 ch1 addr high");
    rd(4'h3, 8'hFF, "R10 ch1 count low");
    rd(4'h3, 8'h00, "R10 ch1 count high");

    wr(4'h4, 8'hAA); wr(4'h7, 8'h55);
    rd(4'h7, 8'h00, "R3 ch3 count low untouched");
    rd(4'h7, 8'h55, "R3 shared pointer put byte high");
    rd(4'h4, 8'hAA, "R3 ch2 addr low");
    rd(4'h4, 8'h00, "R3 ch2 addr high");

    wr(4'h0, 8'h11); wr(4'hC, 8'h5A);
    wr(4'h0, 8'h22); wr(4'h0, 8'h33);
    rd(4'h0, 8'h22, "R4 clear pointer low");
    rd(4'h0, 8'h33, "R4 clear pointer high");

    wr(4'h6, 8'h77);
    rd(4'h9, 8'h00, "R9 non-channel read zero");
    wr(4'h6, 8'h66);
    rd(4'h6, 8'h77, "R3 non-channel read no toggle low");
    rd(4'h6, 8'h66, "R3 non-channel read no toggle high");

    rd(4'h2, 8'h34, "R4 read then clear low");
    wr(4'hC, 8'hFF);
    rd(4'h2, 8'h34, "R4 pointer back to low");
    rd(4'h2, 8'h12, "R4 then high");

    wr(4'hE, 8'h00); chk(mask_o, 4'h0, "R6 clear all mask");
    wr(4'hA, 8'h06); chk(mask_o, 4'h4, "R5 set ch2");
    wr(4'hA, 8'h05); chk(mask_o, 4'h6, "R5 set ch1");
    wr(4'hA, 8'h02); chk(mask_o, 4'h2, "R5 clear ch2");
    wr(4'hA, 8'hF8); chk(mask_o, 4'h2, "R5 clear ch0 upper bits ignored");
    wr(4'hF, 8'hA5); chk(mask_o, 4'h5, "R7 load mask 5");
    wr(4'hF, 8'h0A); chk(mask_o, 4'hA, "R7 load mask A");
    wr(4'hE, 8'hFF); chk(mask_o, 4'h0, "R6 clear with data ignored");

    wr(4'hB, 8'hB6); chk(mode_o, 24'h02D000, "R8 ch2 mode");
    wr(4'hB, 8'h07); chk(mode_o, 24'h06D000, "R8 ch3 mode keeps ch2");

    wr(4'h2, 8'h01); wr(4'hA, 8'h04); wr(4'h2, 8'h02);
    chk(mask_o, 4'h1, "R5 set ch0");
    rd(4'h2, 8'h01, "R3 mask write no toggle low");
    rd(4'h2, 8'h02, "R3 mask write no toggle high");

    rdwr(4'h5, 8'h9C, 8'h00, "R11 read shows old byte");
    rd(4'h5, 8'h00, "R11 single toggle high");
    rd(4'h5, 8'h9C, "R11 write landed low");
    rd(4'h5, 8'h00, "R11 high unchanged");

    @(posedge clk); #1;
    chk(exp_q.size(), 0, "scoreboard drained");
    summary();
  end
endmodule